// File: doc/BRIEF.md
# Fully Associative Translation Cache

The block keeps a small set of recent logical-to-physical page translations and looks all of them up in parallel. Each entry carries a tag (a 3-bit function code and the upper 24 bits of a 32-bit logical address), a valid flag, a history flag and a 24-bit physical page number. A lookup presents a function code and a logical address. One cycle later the block reports whether a translation matched and, on a match, the translated physical address.

The page size is given as log2 of the byte count (8 to 15). Tag bits that fall inside the page offset are left out of the compare. The same offset bits are passed through from the logical address into the physical address. Four commands maintain the contents: load a translation, flush everything, flush the entries that match a given function code and address, and a control-register write that flushes everything unless its flush-disable flag is set. A load first drops any entry that already matches its key. It then writes to a free slot if one exists. Otherwise it evicts the lowest-numbered valid entry whose history flag is clear.

Top module: `xlat_cache`

## Requirements
- R1: After reset every entry is invalid, `res_valid` is 0, and any lookup misses.
- R2: A lookup hits only when an entry is valid, its function code equals `lk_fc`, and its stored tag equals `lk_addr[31:8]` on every compared bit.
- R3: With `page_lg` = p (8..15), bits `lk_addr[p-1:8]` are left out of the compare. Values below 8 act as 8, and values above 15 act as 15.
- R4: On a hit, `res_paddr[31:p]` = stored page bits `[23:p-8]` and `res_paddr[p-1:0]` = `lk_addr[p-1:0]`. On a miss, `res_hit` = 0 and `res_paddr` = 0.
- R5: A lookup with `lk_valid`=1 gives `res_valid`=1 on the next clock. `cmd_op` encodes 1 = load, 2 = flush all, 3 = selective flush and 4 = register write; 0 and 5..7 are idle. A lookup made in a cycle where `cmd_op` is 1..4 is dropped, giving `res_valid`=0 on the next clock.
- R6: A load invalidates every entry that matches (`cmd_fc`, `cmd_vpage`) under the current page size. It then writes the new entry as valid into the lowest-numbered invalid slot if one exists. A reload of an address therefore leaves exactly one translation for it.
- R7: Flush all invalidates every entry in one clock.
- R8: A selective flush invalidates only the entries that match (`cmd_fc`, `cmd_vpage`) under the current page size. All other entries keep hitting.
- R9: A register write with `cmd_fd`=0 invalidates every entry. With `cmd_fd`=1 it leaves every entry in place.
- R10: A hit or a load sets the touched entry's history flag. If this would leave every valid entry flagged, all other flags are cleared. When all entries are valid, a load evicts the lowest-numbered entry whose flag is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| page_lg | input | 4 | log2 of page size in bytes |
| lk_valid | input | 1 | Lookup request |
| lk_fc | input | 3 | Lookup function code |
| lk_addr | input | 32 | Lookup logical address |
| cmd_op | input | 3 | Command code (see R5) |
| cmd_fc | input | 3 | Command function code |
| cmd_vpage | input | 24 | Command logical address bits 31:8 |
| cmd_ppage | input | 24 | Physical page for a load |
| cmd_fd | input | 1 | Flush-disable flag of a register write |
| res_valid | output | 1 | Lookup result present |
| res_hit | output | 1 | Lookup matched |
| res_paddr | output | 32 | Translated physical address |

## Verification
Lookups are run with the same address under two function codes, and with an address one page above a stored one. This separates a match on function code from a match on address. The same pair of addresses is then tried at 256-byte and 4-KiB page sizes, which shows whether offset bits are masked and merged into the result. The cache is filled to all 22 entries and one early entry is touched before a new load. This shows whether the victim comes from the history flags rather than from a fixed slot. A single entry is then freed, and the next load is expected to reuse that free slot.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  typedef enum logic [2:0] {
    OP_IDLE      = 3'd0,
    OP_LOAD      = 3'd1,
    OP_FLUSH_ALL = 3'd2,
    OP_FLUSH_SEL = 3'd3,
    OP_REG_WR    = 3'd4
  } xlat_op_e;
endpackage

// File: rtl/xlat_match.sv
module xlat_match #(
  parameter int N     = 22,
  parameter int FC_W  = 3,
  parameter int TAG_W = 24,
  parameter int SH_W  = 3
) (
  input  logic [N-1:0]            ent_v,
  input  logic [N-1:0][FC_W-1:0]  ent_fc,
  input  logic [N-1:0][TAG_W-1:0] ent_tag,
  input  logic [FC_W-1:0]         key_fc,
  input  logic [TAG_W-1:0]        key_tag,
  input  logic [SH_W-1:0]         shift,
  output logic [N-1:0]            hit_vec
);
  logic [TAG_W-1:0] keep;

  // Tag bits inside the page offset take no part in the compare.
  always_comb begin
    for (int b = 0; b < TAG_W; b++) keep[b] = (b >= int'(shift));
  end

  for (genvar e = 0; e < N; e++) begin : g_cmp
    assign hit_vec[e] = ent_v[e] && (ent_fc[e] == key_fc) &&
                        (((ent_tag[e] ^ key_tag) & keep) == '0);
  end
endmodule

// File: rtl/xlat_victim.sv
module xlat_victim #(
  parameter int N  = 22,
  parameter int IW = 5
) (
  input  logic [N-1:0]  valid,
  input  logic [N-1:0]  hist,
  output logic [IW-1:0] pick,
  output logic          any_free
);
  logic found;

  always_comb begin
    pick     = '0;
    found    = 1'b0;
    any_free = ~&valid;
    // A free slot always wins.
    for (int e = 0; e < N; e++) begin
      if (!found && !valid[e]) begin
        pick  = IW'(e);
        found = 1'b1;
      end
    end
    // Otherwise the first entry not recently touched.
    for (int e = 0; e < N; e++) begin
      if (!found && !hist[e]) begin
        pick  = IW'(e);
        found = 1'b1;
      end
    end
  end
endmodule

// File: rtl/xlat_hist.sv
module xlat_hist #(
  parameter int N  = 22,
  parameter int IW = 5
) (
  input  logic [N-1:0]  valid_nx,
  input  logic [N-1:0]  hist_cur,
  input  logic          touch,
  input  logic [IW-1:0] touch_idx,
  output logic [N-1:0]  hist_nx
);
  logic [N-1:0] one;
  logic [N-1:0] set;

  always_comb begin
    one = touch ? (N'(1) << touch_idx) : '0;
    set = (hist_cur | one) & valid_nx;
    // Saturation: keep only the newest mark.
    if (touch && (set == valid_nx)) hist_nx = one & valid_nx;
    else                            hist_nx = set;
  end
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
  import xlat_pkg::*;
#(
  parameter int N         = 22,
  parameter int FC_W      = 3,
  parameter int TAG_W     = 24,
  parameter int MIN_LG    = 8,
  parameter int MAX_SHIFT = 7
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [3:0]              page_lg,
  input  logic                    lk_valid,
  input  logic [FC_W-1:0]         lk_fc,
  input  logic [TAG_W+MIN_LG-1:0] lk_addr,
  input  logic [2:0]              cmd_op,
  input  logic [FC_W-1:0]         cmd_fc,
  input  logic [TAG_W-1:0]        cmd_vpage,
  input  logic [TAG_W-1:0]        cmd_ppage,
  input  logic                    cmd_fd,
  output logic                    res_valid,
  output logic                    res_hit,
  output logic [TAG_W+MIN_LG-1:0] res_paddr
);
  localparam int ADDR_W = TAG_W + MIN_LG;
  localparam int IW     = $clog2(N);
  localparam int SH_W   = $clog2(MAX_SHIFT + 1);

  logic [N-1:0]            valid_q, hist_q;
  logic [N-1:0][FC_W-1:0]  fc_q;
  logic [N-1:0][TAG_W-1:0] tag_q;
  logic [TAG_W-1:0]        ppage_mem [N];

  logic             cmd_act, is_load;
  logic [SH_W-1:0]  shift;
  logic [FC_W-1:0]  key_fc;
  logic [TAG_W-1:0] key_tag;
  logic [N-1:0]     hit_vec, v_clr, v_nx, h_nx;
  logic [IW-1:0]    hit_idx, victim;
  logic             lk_hit, any_free, touch;
  logic [TAG_W-1:0] ppage_rd;
  logic [ADDR_W-1:0] pa_nx;

  // Command decode: codes outside 1..4 are idle.
  assign is_load = (cmd_op == OP_LOAD);
  assign cmd_act = (cmd_op == OP_LOAD) || (cmd_op == OP_FLUSH_ALL) ||
                   (cmd_op == OP_FLUSH_SEL) || (cmd_op == OP_REG_WR);

  // Page size clamp to the supported range.
  always_comb begin
    int d;
    d = int'(page_lg) - MIN_LG;
    if (d < 0)         d = 0;
    if (d > MAX_SHIFT) d = MAX_SHIFT;
    shift = SH_W'(d);
  end

  // Lookup and commands share one comparator bank.
  assign key_fc  = cmd_act ? cmd_fc : lk_fc;
  assign key_tag = cmd_act ? cmd_vpage : lk_addr[ADDR_W-1:MIN_LG];

  xlat_match #(.N(N), .FC_W(FC_W), .TAG_W(TAG_W), .SH_W(SH_W)) u_match (
    .ent_v  (valid_q),
    .ent_fc (fc_q),
    .ent_tag(tag_q),
    .key_fc (key_fc),
    .key_tag(key_tag),
    .shift  (shift),
    .hit_vec(hit_vec)
  );

  // Lowest matching entry supplies the page.
  always_comb begin
    logic found;
    hit_idx = '0;
    found   = 1'b0;
    for (int e = 0; e < N; e++) begin
      if (!found && hit_vec[e]) begin
        hit_idx = IW'(e);
        found   = 1'b1;
      end
    end
  end

  assign lk_hit = lk_valid && !cmd_act && (|hit_vec);
  assign v_clr  = valid_q & ~hit_vec;

  xlat_victim #(.N(N), .IW(IW)) u_victim (
    .valid   (v_clr),
    .hist    (hist_q & v_clr),
    .pick    (victim),
    .any_free(any_free)
  );

  // Next valid set per command.
  always_comb begin
    v_nx = valid_q;
    case (cmd_op)
      OP_LOAD:      v_nx = v_clr | (N'(1) << victim);
      OP_FLUSH_ALL: v_nx = '0;
      OP_FLUSH_SEL: v_nx = v_clr;
      OP_REG_WR:    v_nx = cmd_fd ? valid_q : '0;
      default:      v_nx = valid_q;
    endcase
  end

  assign touch = lk_hit || is_load;

  xlat_hist #(.N(N), .IW(IW)) u_hist (
    .valid_nx (v_nx),
    .hist_cur (hist_q),
    .touch    (touch),
    .touch_idx(is_load ? victim : hit_idx),
    .hist_nx  (h_nx)
  );

  // Physical address merge: offset from the logical side.
  assign ppage_rd = ppage_mem[hit_idx];
  always_comb begin
    for (int b = 0; b < MIN_LG; b++) pa_nx[b] = lk_addr[b];
    for (int b = 0; b < TAG_W; b++)
      pa_nx[b+MIN_LG] = (b < int'(shift)) ? lk_addr[b+MIN_LG] : ppage_rd[b];
  end

  // Control state with reset.
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q   <= '0;
      hist_q    <= '0;
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_paddr <= '0;
    end else begin
      valid_q   <= v_nx;
      hist_q    <= h_nx;
      res_valid <= lk_valid && !cmd_act;
      res_hit   <= lk_hit;
      res_paddr <= lk_hit ? pa_nx : '0;
    end
  end

  // Entry payload without reset (gated by valid_q).
  always_ff @(posedge clk) begin
    if (is_load) begin
      fc_q[victim]      <= cmd_fc;
      tag_q[victim]     <= cmd_vpage;
      ppage_mem[victim] <= cmd_ppage;
    end
  end

  p_blocked_r5: assert property (@(posedge clk) disable iff (rst)
    cmd_act |=> !res_valid);
  p_hit_in_result_r5: assert property (@(posedge clk) disable iff (rst)
    res_hit |-> res_valid);
  p_miss_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_hit) |-> (res_paddr == '0));
  p_load_lands_r6: assert property (@(posedge clk) disable iff (rst)
    is_load |=> valid_q[$past(victim)]);
  p_free_first_r6: assert property (@(posedge clk) disable iff (rst)
    (is_load && any_free) |-> !v_clr[victim]);
  p_flush_all_r7: assert property (@(posedge clk) disable iff (rst)
    (cmd_op == OP_FLUSH_ALL) |=> (valid_q == '0));
  p_sel_only_clears_r8: assert property (@(posedge clk) disable iff (rst)
    (cmd_op == OP_FLUSH_SEL) |=> ((valid_q & ~$past(valid_q)) == '0));
  p_regwr_flush_r9: assert property (@(posedge clk) disable iff (rst)
    (cmd_op == OP_REG_WR && !cmd_fd) |=> (valid_q == '0));
  p_regwr_keep_r9: assert property (@(posedge clk) disable iff (rst)
    (cmd_op == OP_REG_WR && cmd_fd) |=> (valid_q == $past(valid_q)));
  p_hist_subset_r10: assert property (@(posedge clk) disable iff (rst)
    ((hist_q & ~valid_q) == '0));
endmodule

// File: tb/xlat_cache_bench.sv
module xlat_cache_bench;
  import xlat_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  page_lg = 4'd8;
  logic        lk_valid = 1'b0;
  logic [2:0]  lk_fc = '0;
  logic [31:0] lk_addr = '0;
  logic [2:0]  cmd_op = 3'd0;
  logic [2:0]  cmd_fc = '0;
  logic [23:0] cmd_vpage = '0;
  logic [23:0] cmd_ppage = '0;
  logic        cmd_fd = 1'b0;
  logic        res_valid, res_hit;
  logic [31:0] res_paddr;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  logic        g_v, g_h;
  logic [31:0] g_pa;

  always #2 clk = ~clk;

  xlat_cache u_xlat_cache (
    .clk(clk), .rst(rst), .page_lg(page_lg),
    .lk_valid(lk_valid), .lk_fc(lk_fc), .lk_addr(lk_addr),
    .cmd_op(cmd_op), .cmd_fc(cmd_fc), .cmd_vpage(cmd_vpage),
    .cmd_ppage(cmd_ppage), .cmd_fd(cmd_fd),
    .res_valid(res_valid), .res_hit(res_hit), .res_paddr(res_paddr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] xp(input logic [23:0] pp, input logic [31:0] la, input int lg);
    logic [31:0] lo;
    lo = (32'h1 << lg) - 32'h1;
    return ({pp, 8'h00} & ~lo) | (la & lo);
  endfunction

  task automatic cmd(input logic [2:0] op, input logic [2:0] fc, input logic [31:0] a,
                     input logic [23:0] pp, input logic fd);
    @(negedge clk);
    cmd_op = op; cmd_fc = fc; cmd_vpage = a[31:8]; cmd_ppage = pp; cmd_fd = fd;
    @(posedge clk); #1;
    cmd_op = OP_IDLE;
  endtask

  task automatic look(input logic [2:0] fc, input logic [31:0] a);
    @(negedge clk);
    lk_valid = 1'b1; lk_fc = fc; lk_addr = a;
    @(posedge clk); #1;
    g_v = res_valid; g_h = res_hit; g_pa = res_paddr;
    lk_valid = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 res_valid after reset", {31'd0, res_valid}, 32'd0);
    look(3'd1, 32'h1234_5600);
    chk("R1 lookup misses after reset", {31'd0, g_h}, 32'd0);
    chk("R5 lookup result present", {31'd0, g_v}, 32'd1);
  endtask

  task automatic t_match;
    page_lg = 4'd8;
    cmd(OP_LOAD, 3'd1, 32'h1234_5600, 24'hABCDEF, 1'b0);
    look(3'd1, 32'h1234_567F);
    chk("R2 hit same fc/addr", {31'd0, g_h}, 32'd1);
    chk("R4 paddr merge 256B", g_pa, 32'hABCD_EF7F);
    look(3'd2, 32'h1234_567F);
    chk("R2 fc mismatch misses", {31'd0, g_h}, 32'd0);
    chk("R4 miss paddr zero", g_pa, 32'd0);
    look(3'd1, 32'h1234_5700);
    chk("R2 next page misses", {31'd0, g_h}, 32'd0);
  endtask

  task automatic t_pagesize;
    page_lg = 4'd12;
    look(3'd1, 32'h1234_5A21);
    chk("R3 offset bits ignored at 4K", {31'd0, g_h}, 32'd1);
    chk("R4 paddr merge 4K", g_pa, xp(24'hABCDEF, 32'h1234_5A21, 12));
    look(3'd1, 32'h1234_4600);
    chk("R3 bit 12 still compared", {31'd0, g_h}, 32'd0);
    page_lg = 4'd3;
    look(3'd1, 32'h1234_5A21);
    chk("R3 low page_lg clamps to 8", {31'd0, g_h}, 32'd0);
    page_lg = 4'd8;
  endtask

  task automatic t_timing;
    @(negedge clk);
    lk_valid = 1'b1; lk_fc = 3'd1; lk_addr = 32'h1234_5600;
    cmd_op = OP_LOAD; cmd_fc = 3'd6; cmd_vpage = 24'h777777; cmd_ppage = 24'h0;
    @(posedge clk); #1;
    chk("R5 lookup dropped in command cycle", {31'd0, res_valid}, 32'd0);
    cmd_op = 3'd5;
    @(posedge clk); #1;
    chk("R5 code 5 is idle", {31'd0, res_valid}, 32'd1);
    chk("R5 code 5 lookup hits", {31'd0, res_hit}, 32'd1);
    lk_valid = 1'b0; cmd_op = OP_IDLE;
  endtask

  task automatic t_reload;
    cmd(OP_LOAD, 3'd1, 32'h1234_5600, 24'h111111, 1'b0);
    look(3'd1, 32'h1234_5604);
    chk("R6 reload gives new page", g_pa, 32'h1111_1104);
    cmd(OP_FLUSH_SEL, 3'd1, 32'h1234_5600, 24'h0, 1'b0);
    look(3'd1, 32'h1234_5604);
    chk("R6 no stale duplicate after reload", {31'd0, g_h}, 32'd0);
  endtask

  task automatic t_flush_sel;
    cmd(OP_LOAD, 3'd1, 32'h0000_B000, 24'h00000B, 1'b0);
    cmd(OP_LOAD, 3'd1, 32'h0000_C000, 24'h00000C, 1'b0);
    cmd(OP_FLUSH_SEL, 3'd1, 32'h0000_B000, 24'h0, 1'b0);
    look(3'd1, 32'h0000_B000);
    chk("R8 flushed entry misses", {31'd0, g_h}, 32'd0);
    look(3'd1, 32'h0000_C010);
    chk("R8 other entry kept", g_pa, 32'h0000_0C10);
  endtask

  task automatic t_flush_all;
    cmd(OP_FLUSH_ALL, 3'd0, 32'h0, 24'h0, 1'b0);
    look(3'd1, 32'h0000_C010);
    chk("R7 flush all clears", {31'd0, g_h}, 32'd0);
  endtask

  task automatic t_regwr;
    cmd(OP_LOAD, 3'd4, 32'h0000_D000, 24'h00000D, 1'b0);
    cmd(OP_REG_WR, 3'd0, 32'h0, 24'h0, 1'b1);
    look(3'd4, 32'h0000_D000);
    chk("R9 fd=1 keeps entries", {31'd0, g_h}, 32'd1);
    cmd(OP_REG_WR, 3'd0, 32'h0, 24'h0, 1'b0);
    look(3'd4, 32'h0000_D000);
    chk("R9 fd=0 flushes", {31'd0, g_h}, 32'd0);
  endtask

  task automatic t_replace;
    logic [31:0] base;
    base = 32'h0040_0000;
    cmd(OP_FLUSH_ALL, 3'd0, 32'h0, 24'h0, 1'b0);
    for (int k = 0; k < 22; k++) cmd(OP_LOAD, 3'd3, base + (k << 8), 24'(k), 1'b0);
    look(3'd3, base + 32'h1500);
    chk("R10 last filled entry hits", g_pa, 32'h0000_1500);
    look(3'd3, base);
    chk("R10 entry 0 hits", {31'd0, g_h}, 32'd1);
    cmd(OP_LOAD, 3'd3, 32'h0080_0000, 24'h0000AA, 1'b0);
    look(3'd3, 32'h0080_0000);
    chk("R10 new entry hits", {31'd0, g_h}, 32'd1);
    look(3'd3, base + 32'h100);
    chk("R10 entry 1 evicted", {31'd0, g_h}, 32'd0);
    look(3'd3, base);
    chk("R10 touched entry 0 kept", {31'd0, g_h}, 32'd1);
    look(3'd3, base + 32'h1500);
    chk("R10 entry 21 kept", {31'd0, g_h}, 32'd1);
    cmd(OP_FLUSH_SEL, 3'd3, base + 32'h500, 24'h0, 1'b0);
    cmd(OP_LOAD, 3'd3, 32'h0090_0000, 24'h0000BB, 1'b0);
    look(3'd3, 32'h0090_0000);
    chk("R6 load into freed slot hits", {31'd0, g_h}, 32'd1);
    look(3'd3, base + 32'h200);
    chk("R6 free slot preferred over victim", {31'd0, g_h}, 32'd1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    t_reset();
    t_match();
    t_pagesize();
    t_timing();
    t_reload();
    t_flush_sel();
    t_flush_all();
    t_regwr();
    t_replace();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule